// File: doc/BRIEF.md
# Instruction Prefetch Queue with Early Jump Resolution

This block sits between an instruction memory port and a decode stage. It runs ahead of decode by fetching word-aligned instructions in address order. Returned 32-bit words go into a six-slot queue, and the slot at the head is offered to decode through a valid/ready pair. Each stored slot carries the address it was fetched from, so decode always sees the matching program counter.

The queue also looks at every word as it arrives. An unconditional jump found there has its destination computed at once, and fetching moves to that destination while the jump is still waiting in the queue. When decode later takes the jump, the destination words are usually already queued behind it, and no bubble appears. If that early look is switched off, or decode reaches the jump before the queue can act, the destination is computed when decode takes the jump, and the jump costs three clocks. Conditional branches are treated as not taken. When execute finds one taken, or any other misprediction, it drives a redirect. The redirect empties the queue and discards every fetch still in flight.

Instruction encoding used by the queue: bits [31:26] = 110000 mark an unconditional jump, with destination = own address + (sign-extended bits [25:0] shifted left by 2). Bits [31:26] = 110001 mark a conditional branch, which the queue streams past like any other word. In-flight fetches carry an epoch tag. A response whose tag is not the current epoch is dropped.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted, dec_valid is low and fetch_addr equals RESET_PC (0 by default); the first fetch after reset is from RESET_PC.
- R2: Fetch addresses advance by 4, and with dec_ready held high decode receives one instruction per clock in address order, each with its own address on dec_pc.
- R3: The queue holds at most 6 instructions; with decode stalled, fetch_req drops low once stored plus outstanding fetches reach 6, while dec_valid stays high and dec_pc stays stable.
- R4: A conditional branch (bits [31:26] = 110001) is handed to decode in one clock, and the next instruction handed over is at its address + 4, one clock later.
- R5: A jump's destination is its address plus the sign-extended 26-bit displacement times 4, for both forward and backward displacements.
- R6: With look_en low, the word at the jump's destination is handed to decode 3 clocks after the jump's handshake; queued words behind the jump are discarded.
- R7: With look_en high and the jump queued before decode takes it, the destination word is handed over 1 clock after the jump; the sequential word fetched behind the jump never reaches decode.
- R8: A redirect empties the queue; dec_valid is low in the next clock, and the word at redir_pc is handed over 3 clocks after the redirect cycle.
- R9: When a redirect falls in the same cycle as the arrival of a jump under look_en, the redirect wins: neither the jump nor its destination reaches decode.
- R10: A jump already acted on at arrival causes no second redirect when decode takes it; its successor follows without a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| look_en | input | 1 | Enables jump handling at arrival |
| fetch_req | output | 1 | Fetch request, accepted every cycle it is high |
| fetch_addr | output | 32 | Fetch address |
| fetch_tag | output | EW | Epoch tag of the request |
| rsp_valid | input | 1 | Fetch response valid |
| rsp_instr | input | 32 | Returned instruction word |
| rsp_tag | input | EW | Epoch tag echoed with the response |
| dec_valid | output | 1 | Head slot holds an instruction |
| dec_ready | input | 1 | Decode takes the head slot |
| dec_instr | output | 32 | Head instruction |
| dec_pc | output | 32 | Address of the head instruction |
| redir_valid | input | 1 | Redirect from execute |
| redir_pc | input | 32 | Address to resume at |

## Verification
Two events can fall in the same cycle: an execute redirect and the arrival of a jump that the early look would act on. The bench steers fetching to a backward jump with a first redirect. It then drives a second redirect exactly in the clock where the jump's response is on the port. It passes when decode next sees the second redirect's address followed by its successor, and never the jump or its destination. The same sequence run without the second redirect serves as a control: there the jump and then its backward destination are handed to decode.

// File: rtl/ipb_pkg.sv
package ipb_pkg;

    localparam int unsigned XW = 32;

    typedef logic [XW-1:0] word_t;

    typedef struct packed {
        word_t pc;
        word_t instr;
        logic  seen;
    } slot_t;

    localparam logic [5:0] OP_JUMP = 6'b110000;

    function automatic logic is_jump(input word_t i);
        return i[31:26] == OP_JUMP;
    endfunction

    function automatic word_t jump_target(input word_t pc, input word_t i);
        return pc + {{4{i[25]}}, i[25:0], 2'b00};
    endfunction

endpackage

// File: rtl/ipb_fifo.sv
module ipb_fifo
    import ipb_pkg::*;
#(
    parameter int unsigned DEPTH = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  slot_t                          wdata,
    input  logic                           pop,
    input  logic                           flush,
    output slot_t                          head,
    output logic [$clog2(DEPTH+1)-1:0]     occ
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    slot_t          mem [DEPTH];
    logic [PW-1:0]  rd_ptr;
    logic [PW-1:0]  wr_ptr;
    logic [CW-1:0]  cnt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      cnt <= cnt + CW'(1);
            else if (!push && pop) cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    assign head = mem[rd_ptr];
    assign occ  = cnt;

endmodule

// File: rtl/ipb_fetch.sv
module ipb_fetch
    import ipb_pkg::*;
#(
    parameter int unsigned DEPTH    = 6,
    parameter int unsigned EW       = 3,
    parameter word_t       RESET_PC = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(DEPTH+1)-1:0]     occ,
    input  logic                           jump_now,
    input  word_t                          jump_pc,
    input  logic                           accept,
    input  logic                           rsp_valid,
    input  logic [EW-1:0]                  rsp_tag,
    output logic                           fetch_req,
    output word_t                          fetch_addr,
    output logic [EW-1:0]                  fetch_tag,
    output logic                           tag_ok,
    output word_t                          arr_pc,
    output logic [$clog2(DEPTH+1)-1:0]     outst
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    word_t          pc_q;
    word_t          arr_q;
    logic [EW-1:0]  epoch_q;
    logic [CW-1:0]  outst_q;
    logic [CW:0]    used;

    assign used      = {1'b0, occ} + {1'b0, outst_q};
    assign fetch_req = (used < (CW+1)'(DEPTH)) && !jump_now;
    assign fetch_addr = pc_q;
    assign fetch_tag = epoch_q;
    assign tag_ok    = rsp_tag == epoch_q;
    assign arr_pc    = arr_q;
    assign outst     = outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            arr_q   <= RESET_PC;
            epoch_q <= '0;
            outst_q <= '0;
        end else begin
            if (jump_now) begin
                pc_q    <= jump_pc;
                arr_q   <= jump_pc;
                epoch_q <= epoch_q + EW'(1);
            end else begin
                if (fetch_req) pc_q  <= pc_q + 32'd4;
                if (accept)    arr_q <= arr_q + 32'd4;
            end
            if (fetch_req && !rsp_valid)      outst_q <= outst_q + CW'(1);
            else if (!fetch_req && rsp_valid) outst_q <= outst_q - CW'(1);
        end
    end

endmodule

// File: rtl/ipb_branch_eval.sv
module ipb_branch_eval
    import ipb_pkg::*;
(
    input  word_t pc,
    input  word_t instr,
    output logic  jump,
    output word_t target
);
    assign jump   = is_jump(instr);
    assign target = jump_target(pc, instr);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import ipb_pkg::*;
#(
    parameter int unsigned DEPTH    = 6,
    parameter int unsigned EW       = 3,
    parameter word_t       RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          look_en,
    output logic          fetch_req,
    output logic [31:0]   fetch_addr,
    output logic [EW-1:0] fetch_tag,
    input  logic          rsp_valid,
    input  logic [31:0]   rsp_instr,
    input  logic [EW-1:0] rsp_tag,
    output logic          dec_valid,
    input  logic          dec_ready,
    output logic [31:0]   dec_instr,
    output logic [31:0]   dec_pc,
    input  logic          redir_valid,
    input  logic [31:0]   redir_pc
);
    localparam int unsigned CW    = $clog2(DEPTH + 1);
    localparam int unsigned LANES = 2;

    slot_t          head;
    slot_t          wslot;
    logic [CW-1:0]  occ;
    logic [CW-1:0]  outst;
    word_t          arr_pc;
    logic           tag_ok;
    logic           pop;
    logic           accept;
    logic           dec_jump;
    logic           la_jump;
    logic           flush;
    logic           jump_now;
    word_t          jump_pc;

    word_t          ev_pc   [LANES];
    word_t          ev_in   [LANES];
    logic           ev_jump [LANES];
    word_t          ev_tgt  [LANES];

    // lane 0 watches the arriving word, lane 1 the head slot
    assign ev_pc[0] = arr_pc;
    assign ev_in[0] = rsp_instr;
    assign ev_pc[1] = head.pc;
    assign ev_in[1] = head.instr;

    for (genvar g = 0; g < LANES; g++) begin : g_eval
        ipb_branch_eval u_eval (
            .pc     (ev_pc[g]),
            .instr  (ev_in[g]),
            .jump   (ev_jump[g]),
            .target (ev_tgt[g])
        );
    end

    assign dec_valid = occ != '0;
    assign dec_instr = head.instr;
    assign dec_pc    = head.pc;
    assign pop       = dec_valid && dec_ready;

    assign dec_jump  = pop && ev_jump[1] && !head.seen;
    assign flush     = redir_valid || dec_jump;
    assign accept    = rsp_valid && tag_ok && !flush;
    assign la_jump   = accept && ev_jump[0] && look_en;
    assign jump_now  = flush || la_jump;

    always_comb begin
        if (redir_valid)   jump_pc = redir_pc;
        else if (dec_jump) jump_pc = ev_tgt[1];
        else               jump_pc = ev_tgt[0];
    end

    assign wslot = '{pc: arr_pc, instr: rsp_instr, seen: look_en && ev_jump[0]};

    ipb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .wdata (wslot),
        .pop   (pop),
        .flush (flush),
        .head  (head),
        .occ   (occ)
    );

    ipb_fetch #(.DEPTH(DEPTH), .EW(EW), .RESET_PC(RESET_PC)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .occ        (occ),
        .jump_now   (jump_now),
        .jump_pc    (jump_pc),
        .accept     (accept),
        .rsp_valid  (rsp_valid),
        .rsp_tag    (rsp_tag),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_tag  (fetch_tag),
        .tag_ok     (tag_ok),
        .arr_pc     (arr_pc),
        .outst      (outst)
    );

endmodule

module ipb_chk #(
    parameter int unsigned DEPTH = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [$clog2(DEPTH+1)-1:0]  occ,
    input logic [$clog2(DEPTH+1)-1:0]  outst,
    input logic                        fetch_req,
    input logic [31:0]                 fetch_addr,
    input logic                        redir_valid,
    input logic                        flush,
    input logic                        la_jump,
    input logic [31:0]                 la_tgt,
    input logic                        dec_valid,
    input logic                        dec_ready,
    input logic [31:0]                 dec_pc
);
    // R3
    occupancy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occ} + {1'b0, outst}) <= DEPTH);

    // R2
    seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && $past(fetch_req) && $past(rst_n) && !$past(flush) && !$past(la_jump))
        |-> fetch_addr == $past(fetch_addr) + 32'd4);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready && !redir_valid) |=> (dec_valid && $stable(dec_pc)));

    // R8
    redirect_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !dec_valid);

    // R7
    early_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        la_jump |=> fetch_addr == $past(la_tgt));
endmodule

bind prefetch_queue ipb_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .occ         (occ),
    .outst       (outst),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .redir_valid (redir_valid),
    .flush       (flush),
    .la_jump     (la_jump),
    .la_tgt      (ev_tgt[0]),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .dec_pc      (dec_pc)
);

// File: tb/tb_prefetch_queue.sv
`timescale 1ns/1ps
module tb_prefetch_queue;
    localparam int EW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          look_en = 1'b0;
    logic          fetch_req;
    logic [31:0]   fetch_addr;
    logic [EW-1:0] fetch_tag;
    logic          rsp_valid;
    logic [31:0]   rsp_instr;
    logic [EW-1:0] rsp_tag;
    logic          dec_valid;
    logic          dec_ready = 1'b0;
    logic [31:0]   dec_instr;
    logic [31:0]   dec_pc;
    logic          redir_valid = 1'b0;
    logic [31:0]   redir_pc = '0;

    always #4 clk = ~clk;

    prefetch_queue dut (.*);

    localparam logic [31:0] W_JMP_C  = {6'b110000, 26'h000003D}; // 0xC -> 0x100
    localparam logic [31:0] W_CND_C  = {6'b110001, 26'h000003D};
    localparam logic [31:0] W_J400   = {6'b110000, 26'h3FFFFE0}; // 0x400 -> 0x380

    logic [31:0] c_word = W_CND_C;

    function automatic logic [31:0] prog(input logic [31:0] a);
        if (a == 32'hC)   return c_word;
        if (a == 32'h400) return W_J400;
        return {6'b000001, a[25:0]};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_instr <= '0;
            rsp_tag   <= '0;
        end else begin
            rsp_valid <= fetch_req;
            rsp_instr <= prog(fetch_addr);
            rsp_tag   <= fetch_tag;
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int hs_n = 0;
    logic [31:0] hs_pc [32];
    logic [31:0] hs_in [32];
    int          hs_cy [32];

    always @(negedge clk) begin
        #1;
        cyc = cyc + 1;
        if (dec_valid && dec_ready && hs_n < 32) begin
            hs_pc[hs_n] = dec_pc;
            hs_in[hs_n] = dec_instr;
            hs_cy[hs_n] = cyc;
            hs_n = hs_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        redir_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 dec_valid in reset", {31'd0, dec_valid}, 32'd0);
        chk("R1 fetch_addr in reset", fetch_addr, 32'd0);
        rst_n = 1'b1;
    endtask

    typedef struct packed {
        logic        la;
        logic [31:0] cw;
        logic [31:0] nxt;
        logic [3:0]  gap;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{la: 1'b0, cw: W_CND_C, nxt: 32'h10,  gap: 4'd1},
        '{la: 1'b0, cw: W_JMP_C, nxt: 32'h100, gap: 4'd3},
        '{la: 1'b1, cw: W_JMP_C, nxt: 32'h100, gap: 4'd1},
        '{la: 1'b1, cw: W_CND_C, nxt: 32'h10,  gap: 4'd1}
    };

    task automatic start_stream(input logic la);
        look_en = la;
        c_word = {6'b000001, 26'hC};
        dec_ready = 1'b1;
        do_reset();
        repeat (10) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            string t;
            t = ROWS[i].cw[26] ? "R4" : (ROWS[i].la ? "R7" : "R6");
            look_en = ROWS[i].la;
            c_word = ROWS[i].cw;
            dec_ready = 1'b0;
            do_reset();
            repeat (14) @(negedge clk);
            chk("R3 fetch_req low when full", {31'd0, fetch_req}, 32'd0);
            chk("R3 dec_valid while stalled", {31'd0, dec_valid}, 32'd1);
            hs_n = 0;
            dec_ready = 1'b1;
            repeat (16) @(negedge clk);
            #2;
            chk("R2 order 0", hs_pc[0], 32'h0);
            chk("R2 order 1", hs_pc[1], 32'h4);
            chk("R2 order 2", hs_pc[2], 32'h8);
            chk("R2 order 3", hs_pc[3], 32'hC);
            chk("R2 one per clock", 32'(hs_cy[3] - hs_cy[0]), 32'd3);
            chk({t, " next pc"}, hs_pc[4], ROWS[i].nxt);
            chk({t, " next instr"}, hs_in[4], prog(ROWS[i].nxt));
            chk({t, " gap"}, 32'(hs_cy[4] - hs_cy[3]), 32'(ROWS[i].gap));
            chk("R10 successor pc", hs_pc[5], ROWS[i].nxt + 32'd4);
            chk("R10 successor gap", 32'(hs_cy[5] - hs_cy[4]), 32'd1);
        end

        // R8: external redirect while streaming
        start_stream(1'b0);
        hs_n = 0;
        redir_valid = 1'b1;
        redir_pc = 32'h200;
        @(negedge clk);
        redir_valid = 1'b0;
        #2;
        chk("R8 dec_valid after redirect", {31'd0, dec_valid}, 32'd0);
        repeat (8) @(negedge clk);
        #2;
        chk("R8 resume pc", hs_pc[1], 32'h200);
        chk("R8 resume latency", 32'(hs_cy[1] - hs_cy[0]), 32'd3);
        chk("R8 resume successor", hs_pc[2], 32'h204);

        // R5: backward jump reached via redirect, lookahead on (control case)
        start_stream(1'b1);
        hs_n = 0;
        redir_valid = 1'b1;
        redir_pc = 32'h400;
        @(negedge clk);
        redir_valid = 1'b0;
        repeat (10) @(negedge clk);
        #2;
        chk("R5 jump pc", hs_pc[1], 32'h400);
        chk("R5 jump word", hs_in[1], W_J400);
        chk("R5 backward target", hs_pc[2], 32'h380);
        chk("R5 target successor", hs_pc[3], 32'h384);

        // R9: second redirect in the cycle the jump response arrives
        start_stream(1'b1);
        hs_n = 0;
        redir_valid = 1'b1;
        redir_pc = 32'h400;
        @(negedge clk);
        redir_valid = 1'b0;
        @(negedge clk);
        redir_valid = 1'b1;
        redir_pc = 32'h200;
        @(negedge clk);
        redir_valid = 1'b0;
        repeat (10) @(negedge clk);
        #2;
        chk("R9 redirect wins pc", hs_pc[1], 32'h200);
        chk("R9 redirect successor", hs_pc[2], 32'h204);
        chk("R9 no stale target", {31'd0, (hs_pc[3] == 32'h380 || hs_pc[3] == 32'h400)}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule